// File: doc/BRIEF.md
# Audio Control Register Target on a Two-Wire Serial Bus

This block is the serial-bus front end of an audio processor's control path. It listens on a two-wire bus (SCL clock, SDA open-drain data). It recognises its own fixed 7-bit device address and accepts a pointer byte followed by any number of data bytes. It stores those bytes in a bank of nine 8-bit control registers: input selection, loudness, volume, tone, four speaker attenuators and mute. The register contents are presented in parallel to the analog control logic. A read transfer returns a status byte built from two live mute flags. The byte is taken again after every acknowledge, so the host can poll without repeating the address phase.

The bus lines are oversampled by a much faster system clock. A short synchroniser recovers the bus events: clock edges, START and STOP. A control state machine steps through the transfer phases and issues single-cycle strobes to a datapath. The datapath holds the receive shifter, the register pointer, the register bank and the transmit shifter. The block only ever pulls SDA low. The pad is modelled as a pull-low enable, and the bus level is read back on a separate input.

Top module: `regBusTarget`

## Requirements
- R1: After reset, every register in the bank reads 0xFE and the SDA pull-low output is inactive.
- R2: An address byte whose upper seven bits are 1000100 and whose bit 0 is 0 (write) is acknowledged. Every later byte of that write transfer is also acknowledged. An acknowledge holds SDA low for the whole ninth clock.
- R3: An address byte whose upper seven bits differ from 1000100 is not acknowledged. The block then drives nothing and changes no register until the next START.
- R4: Bits 3:0 of the pointer byte select register 0..8. Register i appears at `regBank[8*i+7:8*i]`. A data byte, received MSB first, is stored unchanged into the selected register, and no other register changes.
- R5: When bit 4 of the pointer byte is 1, each stored data byte advances the pointer by one. The pointer stops at register 8, so further bytes keep overwriting register 8.
- R6: When bit 4 of the pointer byte is 0, every data byte of the transfer overwrites the same register.
- R7: Bits 7:5 of the pointer byte have no effect on the selected register or on the auto-increment behaviour.
- R8: Pointer values 9 to 15 are acknowledged, but data written to them is discarded. Auto-increment does not move the pointer from them.
- R9: An address byte of 1000100 with bit 0 equal to 1 (read) is acknowledged. The block then sends a status byte MSB first: bit 2 = `softMute`, bit 1 = `zeroMute`, and bits 7:3 and bit 0 are 1. A read leaves the register bank unchanged.
- R10: After the host acknowledges a read byte, the next byte is sampled from the flags at that moment. After a host non-acknowledge, the block releases SDA and sends nothing more.
- R11: A START inside a transfer (repeated START) restarts the address phase. A STOP returns the block to idle with SDA released.
- R12: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock level |
| sdaIn | input | 1 | Bus data level as seen on the wire |
| softMute | input | 1 | Soft-mute-active flag reported in status bit 2 |
| zeroMute | input | 1 | Zero-crossing-mute flag reported in status bit 1 |
| sdaOutLow | output | 1 | Pull-low enable for the SDA open-drain pad |
| regBank | output | 72 | All control registers, register i in bits 8*i+7:8*i |

## Verification
The assertions check four things on every cycle:
- the SDA drive never moves while SCL is high;
- the bank changes only on a write strobe, and never on a strobe aimed at pointer 9..15;
- the pointer steps by at most one and never past register 8;
- the block is silent in idle and after an address mismatch.

Only the bench scenarios can show the end-to-end behaviour. These cover:
- that the right byte lands in the right register for each pointer;
- auto-increment bursts that run past the last register;
- that all 127 foreign addresses are rejected;
- the exact bit pattern of the status byte, and its refresh when the flags change between acknowledged reads;
- the recovery after a repeated START.

// File: rtl/regBusPkg.sv
package regBusPkg;
  localparam int BYTE_W = 8;
  localparam int SUB_W  = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_READ,
    ST_READ_ACK,
    ST_IGNORE
  } busStateT;

  typedef struct packed {
    logic shiftRx;
    logic loadPtr;
    logic writeReg;
    logic loadTx;
    logic shiftTx;
  } busStrobeT;
endpackage

// File: rtl/regBusSync.sv
module regBusSync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclNow,
  output logic sdaNow,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] sclPipe;
  logic [PIPE_W-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[PIPE_W-2:0], sclIn};
      sdaPipe <= {sdaPipe[PIPE_W-2:0], sdaIn};
    end
  end

  assign sclNow  = sclPipe[SYNC_STAGES-1];
  assign sclPrev = sclPipe[SYNC_STAGES];
  assign sdaNow  = sdaPipe[SYNC_STAGES-1];
  assign sdaPrev = sdaPipe[SYNC_STAGES];

  assign sclRise  = sclNow & ~sclPrev;
  assign sclFall  = ~sclNow & sclPrev;
  assign startDet = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopDet  = sclNow & sclPrev & ~sdaPrev & sdaNow;
endmodule

// File: rtl/regBusCtrl.sv
module regBusCtrl
  import regBusPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              sdaNow,
  input  logic [BYTE_W-1:0] rxByte,
  output busStrobeT         strobes,
  output logic              ackDrive,
  output logic              txDrive,
  output busStateT          stateQ
);
  logic [3:0] bitCnt;
  logic       isRead;
  logic       masterNack;
  logic       inRecv;
  logic       byteDone;

  assign inRecv   = (stateQ == ST_ADDR) || (stateQ == ST_SUB) || (stateQ == ST_DATA);
  assign byteDone = inRecv && sclFall && (bitCnt == 4'd8);

  always_comb begin
    strobes = '0;
    if (!startDet && !stopDet) begin
      strobes.shiftRx  = inRecv && sclRise && (bitCnt < 4'd8);
      strobes.loadPtr  = byteDone && (stateQ == ST_SUB);
      strobes.writeReg = byteDone && (stateQ == ST_DATA);
      strobes.loadTx   = sclFall && (((stateQ == ST_ADDR_ACK) && isRead) ||
                                     ((stateQ == ST_READ_ACK) && !masterNack));
      strobes.shiftTx  = sclFall && (stateQ == ST_READ) && (bitCnt != 4'd7);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      bitCnt     <= '0;
      isRead     <= 1'b0;
      masterNack <= 1'b0;
      ackDrive   <= 1'b0;
      txDrive    <= 1'b0;
    end else if (startDet) begin
      stateQ   <= ST_ADDR;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txDrive  <= 1'b0;
    end else if (stopDet) begin
      stateQ   <= ST_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txDrive  <= 1'b0;
    end else begin
      case (stateQ)
        ST_ADDR, ST_SUB, ST_DATA: begin
          if (sclRise && bitCnt < 4'd8) bitCnt <= bitCnt + 4'd1;
          if (byteDone) begin
            if (stateQ == ST_ADDR) begin
              if (rxByte[7:1] == DEV_ADDR) begin
                ackDrive <= 1'b1;
                isRead   <= rxByte[0];
                stateQ   <= ST_ADDR_ACK;
              end else begin
                stateQ <= ST_IGNORE;
              end
            end else begin
              ackDrive <= 1'b1;
              stateQ   <= (stateQ == ST_SUB) ? ST_SUB_ACK : ST_DATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            ackDrive <= 1'b0;
            bitCnt   <= '0;
            if (isRead) begin
              txDrive <= 1'b1;
              stateQ  <= ST_READ;
            end else begin
              stateQ <= ST_SUB;
            end
          end
        end
        ST_SUB_ACK, ST_DATA_ACK: begin
          if (sclFall) begin
            ackDrive <= 1'b0;
            bitCnt   <= '0;
            stateQ   <= ST_DATA;
          end
        end
        ST_READ: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              txDrive <= 1'b0;
              bitCnt  <= '0;
              stateQ  <= ST_READ_ACK;
            end else begin
              bitCnt <= bitCnt + 4'd1;
            end
          end
        end
        ST_READ_ACK: begin
          if (sclRise) masterNack <= sdaNow;
          if (sclFall) begin
            if (masterNack) begin
              stateQ <= ST_IGNORE;
            end else begin
              txDrive <= 1'b1;
              bitCnt  <= '0;
              stateQ  <= ST_READ;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/regBusData.sv
module regBusData
  import regBusPkg::*;
#(
  parameter int          NUM_REGS  = 9,
  parameter logic [7:0]  RESET_VAL = 8'hFE
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  busStrobeT                  strobes,
  input  logic                       sdaNow,
  input  logic                       softMute,
  input  logic                       zeroMute,
  output logic [BYTE_W-1:0]          rxByte,
  output logic                       txMsb,
  output logic [SUB_W-1:0]           ptrQ,
  output logic [NUM_REGS*BYTE_W-1:0] regBank
);
  localparam logic [SUB_W-1:0] LAST_IDX = SUB_W'(NUM_REGS - 1);

  logic              autoInc;
  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] statusByte;

  assign statusByte = {5'b11111, softMute, zeroMute, 1'b1};
  assign txMsb      = txShift[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      txShift <= '1;
    end else begin
      if (strobes.shiftRx) rxByte <= {rxByte[BYTE_W-2:0], sdaNow};
      if (strobes.loadTx)       txShift <= statusByte;
      else if (strobes.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ    <= '0;
      autoInc <= 1'b0;
    end else if (strobes.loadPtr) begin
      ptrQ    <= rxByte[SUB_W-1:0];
      autoInc <= rxByte[SUB_W];
    end else if (strobes.writeReg && autoInc && ptrQ < LAST_IDX) begin
      ptrQ <= ptrQ + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    logic [BYTE_W-1:0] regQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                    regQ <= RESET_VAL;
      else if (strobes.writeReg && ptrQ == SUB_W'(g)) regQ <= rxByte;
    end
    assign regBank[g*BYTE_W +: BYTE_W] = regQ;
  end
endmodule

// File: rtl/regBusTarget.sv
module regBusTarget
  import regBusPkg::*;
#(
  parameter int         NUM_REGS    = 9,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'b1000100,
  parameter logic [7:0] RESET_VAL   = 8'hFE
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  logic                  softMute,
  input  logic                  zeroMute,
  output logic                  sdaOutLow,
  output logic [NUM_REGS*8-1:0] regBank
);
  logic              sclNow, sdaNow, sclRise, sclFall, startDet, stopDet;
  logic              ackDrive, txDrive, txMsb;
  logic [BYTE_W-1:0] rxByte;
  logic [SUB_W-1:0]  ptrQ;
  busStrobeT         strobes;
  busStateT          ctrlState;

  regBusSync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclNow(sclNow), .sdaNow(sdaNow), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  regBusCtrl #(.DEV_ADDR(DEV_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaNow(sdaNow), .rxByte(rxByte),
    .strobes(strobes), .ackDrive(ackDrive), .txDrive(txDrive), .stateQ(ctrlState)
  );

  regBusData #(.NUM_REGS(NUM_REGS), .RESET_VAL(RESET_VAL)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sdaNow(sdaNow),
    .softMute(softMute), .zeroMute(zeroMute), .rxByte(rxByte), .txMsb(txMsb),
    .ptrQ(ptrQ), .regBank(regBank)
  );

  assign sdaOutLow = ackDrive | (txDrive & ~txMsb);
endmodule

// File: rtl/regBusChecker.sv
module regBusChecker
  import regBusPkg::*;
#(
  parameter int NUM_REGS = 9
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclNow,
  input logic                  sdaOutLow,
  input logic [NUM_REGS*8-1:0] regBank,
  input logic [SUB_W-1:0]      ptrQ,
  input busStrobeT             strobes,
  input busStateT              ctrlState
);
  localparam logic [SUB_W-1:0] LAST_IDX = SUB_W'(NUM_REGS - 1);

  // R12: drive changes only while SCL is low
  p_drive_scl_low_r12: assert property (@(posedge clk) disable iff (!rstN)
    (sclNow && $past(sclNow)) |-> $stable(sdaOutLow));

  // R4: the bank only moves on a write strobe
  p_bank_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.writeReg |=> $stable(regBank));

  // R8: writes aimed past the bank are dropped
  p_discard_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.writeReg && ptrQ > LAST_IDX) |=> $stable(regBank));

  // R5: pointer steps by at most one and never beyond the last register
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writeReg |=> (ptrQ == $past(ptrQ)) ||
                         ((ptrQ == $past(ptrQ) + 4'd1) && (ptrQ <= LAST_IDX)));

  // R3: silent after an address mismatch
  p_ignore_silent_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_IGNORE && $past(ctrlState) == ST_IGNORE) |-> !sdaOutLow);

  // R11: nothing driven while idle
  p_idle_silent_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_IDLE) |-> !sdaOutLow);
endmodule

bind regBusTarget regBusChecker #(.NUM_REGS(NUM_REGS)) uChecker (
  .clk(clk), .rstN(rstN), .sclNow(sclNow), .sdaOutLow(sdaOutLow),
  .regBank(regBank), .ptrQ(ptrQ), .strobes(strobes), .ctrlState(ctrlState)
);

// File: tb/regBusTarget_test.sv
module regBusTarget_test;
  localparam int NREG = 9;
  localparam int Q    = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic softMute = 1'b0;
  logic zeroMute = 1'b0;
  logic sdaOutLow;
  logic [NREG*8-1:0] regBank;
  logic sdaBus;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;
  logic [7:0] model [NREG];
  logic [7:0] burst [16];

  assign sdaBus = sdaM & ~sdaOutLow;

  always #2 clk = ~clk;

  regBusTarget uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .softMute(softMute), .zeroMute(zeroMute),
    .sdaOutLow(sdaOutLow), .regBank(regBank)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(1);
    sdaM = 1'b0; waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(1);
    sclM = 1'b1; waitQ(2);
    sdaM = 1'b1; waitQ(2);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitQ(1);
      sclM = 1'b1; waitQ(2);
      sclM = 1'b0; waitQ(1);
    end
    sdaM = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(1);
    acked = ~sdaBus;
    waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic readByte(input logic hostNack, input logic nextSm, input logic nextZm,
                          output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ(1);
      sclM = 1'b1; waitQ(1);
      b[i] = sdaBus;
      waitQ(1);
      sclM = 1'b0;
    end
    softMute = nextSm;
    zeroMute = nextZm;
    waitQ(1);
    sdaM = hostNack; waitQ(1);
    sclM = 1'b1; waitQ(2);
    sclM = 1'b0; waitQ(1);
    sdaM = 1'b1;
  endtask

  task automatic compareAll(input string req);
    for (int i = 0; i < NREG; i++) chk(req, 32'(regBank[i*8 +: 8]), 32'(model[i]));
  endtask

  // full write transfer: address, pointer byte, n data bytes from burst[]
  task automatic writeXfer(input logic [7:0] sub, input int n, input string req);
    logic ack;
    busStart();
    sendByte(8'h88, ack); chk({req, " R2 addr ack"}, 32'(ack), 32'd1);
    sendByte(sub, ack);   chk({req, " R2 sub ack"}, 32'(ack), 32'd1);
    for (int k = 0; k < n; k++) begin
      sendByte(burst[k], ack);
      chk({req, " R2 data ack"}, 32'(ack), 32'd1);
    end
    busStop();
  endtask

  // bench model of the pointer behaviour
  task automatic modelWrite(input logic [7:0] sub, input int n);
    int p = int'(sub[3:0]);
    for (int k = 0; k < n; k++) begin
      if (p < NREG) model[p] = burst[k];
      if (sub[4] && p < NREG - 1) p++;
    end
  endtask

  initial begin
    logic ack;
    logic [7:0] rb;
    for (int i = 0; i < NREG; i++) model[i] = 8'hFE;
    repeat (4) @(negedge clk);
    compareAll("R1 reset value");
    chk("R1 sda released", 32'(sdaOutLow), 32'd0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R4: single write to every register
    for (int r = 0; r < NREG; r++) begin
      burst[0] = 8'((r * 37 + 11) ^ 8'hA5);
      writeXfer(8'(r), 1, "R4");
      modelWrite(8'(r), 1);
      compareAll("R4 single write");
    end

    // R5: burst past the last register
    for (int k = 0; k < 12; k++) burst[k] = 8'(8'h30 + k * 7);
    writeXfer(8'h10, 12, "R5");
    modelWrite(8'h10, 12);
    compareAll("R5 auto-increment burst");
    for (int k = 0; k < 3; k++) burst[k] = 8'(8'hC1 + k);
    writeXfer(8'h16, 3, "R5");
    modelWrite(8'h16, 3);
    compareAll("R5 burst from 6");

    // R6: no increment
    for (int k = 0; k < 3; k++) burst[k] = 8'(8'h5A ^ (k << 4));
    writeXfer(8'h05, 3, "R6");
    modelWrite(8'h05, 3);
    compareAll("R6 same register");

    // R7: upper pointer bits ignored
    burst[0] = 8'h12; burst[1] = 8'h34;
    writeXfer(8'hE3, 2, "R7");
    modelWrite(8'h03, 2);
    compareAll("R7 bits 7:5 set, no increment");
    burst[0] = 8'h9A; burst[1] = 8'hBC; burst[2] = 8'hDE; burst[3] = 8'h0F;
    writeXfer(8'hF6, 4, "R7");
    modelWrite(8'h16, 4);
    compareAll("R7 bits 7:5 set, increment");

    // R8: out-of-range pointers
    for (int s = 9; s < 16; s++) begin
      burst[0] = 8'h00; burst[1] = 8'h77;
      writeXfer(8'(s), 2, "R8");
      writeXfer(8'(s | 16), 2, "R8");
    end
    compareAll("R8 discarded writes");

    // R3: every foreign address
    for (int a = 0; a < 128; a++) begin
      if (a == 7'h44) continue;
      busStart();
      sendByte({7'(a), 1'b0}, ack);
      chk("R3 foreign address nack", 32'(ack), 32'd0);
      sendByte(8'h01, ack);
      chk("R3 ignored after mismatch", 32'(ack), 32'd0);
      sendByte(8'h00, ack);
      busStop();
    end
    compareAll("R3 no write on mismatch");

    // R9: status byte for every flag pair
    for (int f = 0; f < 4; f++) begin
      softMute = f[1]; zeroMute = f[0];
      busStart();
      sendByte(8'h89, ack);
      chk("R9 read addr ack", 32'(ack), 32'd1);
      readByte(1'b1, f[1], f[0], rb);
      chk("R9 status byte", 32'(rb), 32'({5'b11111, f[1], f[0], 1'b1}));
      busStop();
    end
    compareAll("R9 read leaves bank");

    // R10: refresh after each host ack, release after nack
    softMute = 1'b0; zeroMute = 1'b0;
    busStart();
    sendByte(8'h89, ack);
    readByte(1'b0, 1'b1, 1'b0, rb);
    chk("R10 first read", 32'(rb), 32'hF9);
    readByte(1'b0, 1'b0, 1'b1, rb);
    chk("R10 refreshed read", 32'(rb), 32'hFD);
    readByte(1'b0, 1'b1, 1'b1, rb);
    chk("R10 refreshed again", 32'(rb), 32'hFB);
    readByte(1'b1, 1'b0, 1'b0, rb);
    chk("R10 last before nack", 32'(rb), 32'hFF);
    chk("R10 released after nack", 32'(sdaOutLow), 32'd0);
    sendByte(8'h00, ack);
    chk("R10 silent after nack", 32'(ack), 32'd0);
    busStop();

    // R11: repeated start, and empty start/stop
    busStart();
    sendByte(8'h88, ack);
    sendByte(8'h02, ack);
    sendByte(8'h3C, ack);
    busStart();
    sendByte(8'h88, ack);
    chk("R11 addr after repeated start", 32'(ack), 32'd1);
    sendByte(8'h07, ack);
    sendByte(8'hC3, ack);
    busStop();
    model[2] = 8'h3C; model[7] = 8'hC3;
    compareAll("R11 repeated start");
    busStart();
    busStop();
    chk("R11 idle after stop", 32'(sdaOutLow), 32'd0);
    burst[0] = 8'h66;
    writeXfer(8'h00, 1, "R11");
    model[0] = 8'h66;
    compareAll("R11 write after empty transfer");

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule